// File: doc/BRIEF.md
# Multi-Step ADC Conversion Sequencer

The sequencer walks an ordered list of conversion steps and drives a converter through a request/acknowledge handshake. It has seventeen step slots. Slot 0 is a charge step that only waits out its open delay. Slots 1 to 16 are general conversion steps. Every slot has its own settle (open) delay, sample delay, averaging setting, input channel, trigger mode and destination FIFO. A general step waits its open delay, then runs sample-delay-plus-conversion rounds, one round for each averaged sample. It then pushes the averaged 12-bit result into one of two external FIFOs. The result word can carry the number of the step that produced it.

Software programs the block through a write-only register port and then sets the run bit. The block reports a busy bit, sticky event flags (end of sequence and one overrun per FIFO) and live FIFO-threshold bits. A single interrupt line is the OR of the masked status bits. The converter and the FIFOs are outside the block. The FIFOs report full and level, and the bench models the converter so that it answers after 13 cycles.

Top module: `adc_step_seq`

## Requirements
- R1: After reset, busy, adc_req, both push strobes, status and irq are all 0.
- R2: While control bit 0 (run) is 0, no step starts. Clearing run during a step returns busy to 0 on the following cycle and pushes nothing.
- R3: Enabled slots are processed in ascending order of their enable bit: bit 0 is the charge slot, and bit k (k = 1..16) is general step k-1. The lowest enabled slot runs again after the highest one.
- R4: Busy is high from the first open-delay cycle to the push cycle. A general step is busy for open + 2 + N*(sample + 14) cycles when the converter acknowledges in the 13th cycle of a request.
- R5: Averaging field a sits in config bits [4:2]. N = 2^min(a,4) samples are summed into 16 bits, and the pushed data is that sum shifted right by min(a,4).
- R6: The result word carries the data in bits [11:0]. When control bit 1 is set, bits [19:16] hold the step number (slot - 1); otherwise they are 0. All other bits are 0.
- R7: Config bit 26 set sends the result to FIFO1; otherwise it goes to FIFO0. At most one push strobe is high in any cycle.
- R8: If the target FIFO is full, nothing is pushed and the overrun flag for that FIFO is set: status bit 1 for FIFO0, bit 2 for FIFO1.
- R9: When a pass finds no enabled slot above the last completed one, status bit 0 (end of sequence) is set. Writing 1s to address 0x04 clears the matching flags in bits [2:0].
- R10: Mode config[1:0] controls how a step repeats. Mode 0 clears the slot's enable bit when the step completes. Mode 1 keeps the bit, so the step repeats every pass. Modes 2 and 3 wait, before the open delay, until hw_trig is high.
- R11: The charge slot (slot 0) waits its open delay (busy for open + 1 cycles) and then moves on, with no conversion and no push.
- R12: Status bit 3 (or bit 4) is 1 when the FIFO0 (or FIFO1) threshold is nonzero and the FIFO level is at or above it. irq is the OR of status[4:0] ANDed with the mask register.
- R13: Register addresses are as follows.
  - 0x00: control (bit 0 run, bit 1 tag).
  - 0x01: enable, 17 bits.
  - 0x02 and 0x03: thresholds for FIFO0 and FIFO1.
  - 0x04: flag clear.
  - 0x05: interrupt mask.
  - 0x20+2s: config of slot s. Mode [1:0], average [4:2], channel [22:19], FIFO [26].
  - 0x21+2s: delays of slot s. Open [17:0], sample [31:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register address |
| wr_data | input | 32 | Register write data |
| hw_trig | input | 1 | Hardware trigger for modes 2 and 3 |
| adc_req | output | 1 | Conversion request |
| adc_chan | output | 4 | Channel of the current step |
| adc_ack | input | 1 | Conversion done |
| adc_data | input | 12 | Converted sample |
| fifo0_push | output | 1 | Push strobe, FIFO0 |
| fifo1_push | output | 1 | Push strobe, FIFO1 |
| push_word | output | 32 | Result word |
| fifo0_full | input | 1 | FIFO0 full |
| fifo1_full | input | 1 | FIFO1 full |
| fifo0_level | input | 7 | FIFO0 fill level |
| fifo1_level | input | 7 | FIFO1 fill level |
| busy | output | 1 | A step is in progress |
| status | output | 5 | {thr1, thr0, ovr1, ovr0, eos} |
| irq | output | 1 | Masked interrupt |

## Verification
The checker module watches these on every cycle:
- conversion requests occur only inside a busy step;
- a result either goes to one FIFO or raises one overrun flag, never both;
- nothing is pushed into a full FIFO;
- busy drops one cycle after run is cleared;
- a hardware-synchronised step starts only while the trigger is high;
- result words keep their unused bits at zero;
- end of sequence is flagged only between steps.

The bench scenarios are needed for the behaviours that span many cycles:
- averaged data values and step tags;
- ascending slot order;
- exact step durations;
- one-shot retirement and continuous repetition;
- charge-only steps;
- threshold interrupts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int DATA_W       = 12;
  localparam int ACC_W        = 16;
  localparam int OPEN_W       = 18;
  localparam int SAMP_W       = 8;
  localparam int CFG_FIFO_BIT = 26;
  localparam int CFG_CHAN_LSB = 19;
  localparam int DLY_SAMP_LSB = 24;
  localparam logic [2:0] AVG_LIMIT = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_TRIG, ST_OPEN, ST_SAMP, ST_CONV, ST_PUSH
  } seq_state_e;

  // averaging exponent, saturated at 16 samples
  function automatic logic [2:0] avg_eff(input logic [2:0] a);
    return (a > AVG_LIMIT) ? AVG_LIMIT : a;
  endfunction

  function automatic logic [4:0] avg_count(input logic [2:0] a);
    return 5'd1 << avg_eff(a);
  endfunction

  function automatic logic [DATA_W-1:0] avg_result(input logic [ACC_W-1:0] sum,
                                                   input logic [2:0] a);
    logic [ACC_W-1:0] s;
    s = sum >> avg_eff(a);
    return s[DATA_W-1:0];
  endfunction

  function automatic logic [31:0] pack_result(input logic [DATA_W-1:0] d,
                                              input logic tag,
                                              input logic [3:0] id);
    return {12'd0, (tag ? id : 4'd0), 4'd0, d};
  endfunction

endpackage

// File: rtl/seq_pick.sv
module seq_pick #(
  parameter int N  = 17,
  parameter int IW = 5
) (
  input  logic [N-1:0]  en,
  input  logic [IW-1:0] from,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest enabled slot at or above 'from'
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (en[i] && (IW'(i) >= from)) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/seq_regs.sv
module seq_regs #(
  parameter int NSLOT = 17,
  parameter int AW    = 7,
  parameter int LVL_W = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [31:0]            wr_data,
  input  logic [NSLOT-1:0]       oneshot_clr,
  input  logic [2:0]             flag_set,
  output logic                   run_en,
  output logic                   tag_en,
  output logic [NSLOT-1:0]       step_en,
  output logic [NSLOT-1:0][31:0] cfg,
  output logic [NSLOT-1:0][31:0] dly,
  output logic [LVL_W-1:0]       thr0,
  output logic [LVL_W-1:0]       thr1,
  output logic [4:0]             irq_mask,
  output logic [2:0]             flags
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STEN = AW'(1);
  localparam logic [AW-1:0] A_THR0 = AW'(2);
  localparam logic [AW-1:0] A_THR1 = AW'(3);
  localparam logic [AW-1:0] A_FLAG = AW'(4);
  localparam logic [AW-1:0] A_MASK = AW'(5);
  localparam int            SLOT_BASE = 32;

  logic [2:0] flag_clr;
  assign flag_clr = (wr_en && wr_addr == A_FLAG) ? wr_data[2:0] : 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      tag_en   <= 1'b0;
      step_en  <= '0;
      thr0     <= '0;
      thr1     <= '0;
      irq_mask <= '0;
      flags    <= '0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) begin
        run_en <= wr_data[0];
        tag_en <= wr_data[1];
      end
      if (wr_en && wr_addr == A_STEN) step_en <= wr_data[NSLOT-1:0];
      else                            step_en <= step_en & ~oneshot_clr;
      if (wr_en && wr_addr == A_THR0) thr0 <= wr_data[LVL_W-1:0];
      if (wr_en && wr_addr == A_THR1) thr1 <= wr_data[LVL_W-1:0];
      if (wr_en && wr_addr == A_MASK) irq_mask <= wr_data[4:0];
      flags <= (flags & ~flag_clr) | flag_set;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [AW-1:0] CFG_A = AW'(SLOT_BASE + 2 * g);
    localparam logic [AW-1:0] DLY_A = AW'(SLOT_BASE + 2 * g + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[g] <= '0;
        dly[g] <= '0;
      end else if (wr_en) begin
        if (wr_addr == CFG_A) cfg[g] <= wr_data;
        if (wr_addr == DLY_A) dly[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/seq_core.sv
module seq_core
  import adc_seq_pkg::*;
#(
  parameter int NSLOT = 17,
  parameter int IW    = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_en,
  input  logic                   tag_en,
  input  logic [NSLOT-1:0]       step_en,
  input  logic [NSLOT-1:0][31:0] cfg,
  input  logic [NSLOT-1:0][31:0] dly,
  input  logic                   hw_trig,
  input  logic                   adc_ack,
  input  logic [DATA_W-1:0]      adc_data,
  input  logic                   f0_full,
  input  logic                   f1_full,
  output logic                   adc_req,
  output logic [3:0]             adc_chan,
  output logic                   push0,
  output logic                   push1,
  output logic [31:0]            push_word,
  output logic                   busy,
  output logic [NSLOT-1:0]       oneshot_clr,
  output logic                   eos_evt,
  output logic                   ovr0_evt,
  output logic                   ovr1_evt,
  output logic                   step_start,
  output logic                   cur_hw
);
  seq_state_e        st;
  logic [IW-1:0]     ptr, idx, pick_idx, step_id;
  logic              found;
  logic [OPEN_W-1:0] cnt;
  logic [3:0]        left;
  logic [ACC_W-1:0]  acc;

  seq_pick #(.N(NSLOT), .IW(IW)) u_pick (
    .en(step_en), .from(ptr), .found(found), .idx(pick_idx)
  );

  logic [31:0]       cur_cfg, cur_dly;
  logic [1:0]        cur_mode;
  logic [2:0]        cur_avg;
  logic              to_f1, is_charge, at_push, finishing, trig_ok;
  logic [OPEN_W-1:0] open_len, samp_len;

  assign cur_cfg   = cfg[idx];
  assign cur_dly   = dly[idx];
  assign cur_mode  = cur_cfg[1:0];
  assign cur_hw    = cur_mode[1];
  assign cur_avg   = cur_cfg[4:2];
  assign to_f1     = cur_cfg[CFG_FIFO_BIT];
  assign adc_chan  = cur_cfg[CFG_CHAN_LSB +: 4];
  assign open_len  = cur_dly[OPEN_W-1:0];
  assign samp_len  = OPEN_W'(cur_dly[DLY_SAMP_LSB +: SAMP_W]);
  assign is_charge = (idx == '0);
  assign step_id   = idx - IW'(1);

  assign trig_ok    = !cur_hw || hw_trig;
  assign step_start = run_en && st == ST_TRIG && step_en[idx] && trig_ok;
  assign at_push    = run_en && st == ST_PUSH;
  assign finishing  = at_push || (run_en && st == ST_OPEN && cnt == '0 && is_charge);

  assign push0    = at_push && !to_f1 && !f0_full;
  assign push1    = at_push &&  to_f1 && !f1_full;
  assign ovr0_evt = at_push && !to_f1 &&  f0_full;
  assign ovr1_evt = at_push &&  to_f1 &&  f1_full;
  assign push_word = pack_result(avg_result(acc, cur_avg), tag_en, step_id[3:0]);

  assign oneshot_clr = (finishing && cur_mode == 2'd0) ? (NSLOT'(1) << idx) : '0;
  assign eos_evt     = run_en && st == ST_SCAN && !found && ptr != '0;
  assign busy        = (st == ST_OPEN) || (st == ST_SAMP) || (st == ST_CONV) || (st == ST_PUSH);
  assign adc_req     = (st == ST_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      ptr  <= '0;
      idx  <= '0;
      cnt  <= '0;
      left <= '0;
      acc  <= '0;
    end else if (!run_en) begin
      st  <= ST_IDLE;
      ptr <= '0;
    end else begin
      unique case (st)
        ST_IDLE: st <= ST_SCAN;
        ST_SCAN: begin
          if (found) begin
            idx <= pick_idx;
            st  <= ST_TRIG;
          end else begin
            ptr <= '0;
            st  <= ST_IDLE;
          end
        end
        ST_TRIG: begin
          if (!step_en[idx]) begin
            st <= ST_SCAN;
          end else if (trig_ok) begin
            st   <= ST_OPEN;
            cnt  <= open_len;
            acc  <= '0;
            left <= 4'(avg_count(cur_avg) - 5'd1);
          end
        end
        ST_OPEN: begin
          if (cnt == '0) begin
            if (is_charge) begin
              ptr <= idx + IW'(1);
              st  <= ST_SCAN;
            end else begin
              cnt <= samp_len;
              st  <= ST_SAMP;
            end
          end else begin
            cnt <= cnt - OPEN_W'(1);
          end
        end
        ST_SAMP: begin
          if (cnt == '0) st <= ST_CONV;
          else           cnt <= cnt - OPEN_W'(1);
        end
        ST_CONV: begin
          if (adc_ack) begin
            acc <= acc + ACC_W'(adc_data);
            if (left == '0) begin
              st <= ST_PUSH;
            end else begin
              left <= left - 4'd1;
              cnt  <= samp_len;
              st   <= ST_SAMP;
            end
          end
        end
        ST_PUSH: begin
          ptr <= idx + IW'(1);
          st  <= ST_SCAN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_step_seq.sv
module adc_step_seq #(
  parameter int NSLOT = 17,
  parameter int AW    = 7,
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             hw_trig,
  output logic             adc_req,
  output logic [3:0]       adc_chan,
  input  logic             adc_ack,
  input  logic [11:0]      adc_data,
  output logic             fifo0_push,
  output logic             fifo1_push,
  output logic [31:0]      push_word,
  input  logic             fifo0_full,
  input  logic             fifo1_full,
  input  logic [LVL_W-1:0] fifo0_level,
  input  logic [LVL_W-1:0] fifo1_level,
  output logic             busy,
  output logic [4:0]       status,
  output logic             irq
);
  localparam int IW = $clog2(NSLOT + 1);

  logic                   run_en, tag_en;
  logic [NSLOT-1:0]       step_en, oneshot_clr;
  logic [NSLOT-1:0][31:0] cfg, dly;
  logic [LVL_W-1:0]       thr0, thr1;
  logic [4:0]             irq_mask;
  logic [2:0]             flags;
  logic                   eos_evt, ovr0_evt, ovr1_evt, step_start, cur_hw;
  logic                   thr0_hit, thr1_hit;

  seq_regs #(.NSLOT(NSLOT), .AW(AW), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .oneshot_clr(oneshot_clr), .flag_set({ovr1_evt, ovr0_evt, eos_evt}),
    .run_en(run_en), .tag_en(tag_en), .step_en(step_en), .cfg(cfg), .dly(dly),
    .thr0(thr0), .thr1(thr1), .irq_mask(irq_mask), .flags(flags)
  );

  seq_core #(.NSLOT(NSLOT), .IW(IW)) u_core (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tag_en(tag_en), .step_en(step_en),
    .cfg(cfg), .dly(dly), .hw_trig(hw_trig), .adc_ack(adc_ack), .adc_data(adc_data),
    .f0_full(fifo0_full), .f1_full(fifo1_full), .adc_req(adc_req), .adc_chan(adc_chan),
    .push0(fifo0_push), .push1(fifo1_push), .push_word(push_word), .busy(busy),
    .oneshot_clr(oneshot_clr), .eos_evt(eos_evt), .ovr0_evt(ovr0_evt),
    .ovr1_evt(ovr1_evt), .step_start(step_start), .cur_hw(cur_hw)
  );

  assign thr0_hit = (thr0 != '0) && (fifo0_level >= thr0);
  assign thr1_hit = (thr1 != '0) && (fifo1_level >= thr1);
  assign status   = {thr1_hit, thr0_hit, flags};
  assign irq      = |(status & irq_mask);
endmodule

// File: rtl/adc_step_seq_chk.sv
module adc_step_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        adc_req,
  input logic        fifo0_push,
  input logic        fifo1_push,
  input logic        fifo0_full,
  input logic        fifo1_full,
  input logic        ovr0_evt,
  input logic        ovr1_evt,
  input logic        run_en,
  input logic        eos_evt,
  input logic        step_start,
  input logic        cur_hw,
  input logic        hw_trig,
  input logic [31:0] push_word
);
  assert_req_in_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |-> busy);

  assert_one_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo0_push, fifo1_push, ovr0_evt, ovr1_evt}));

  assert_no_push_full0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo0_push |-> !fifo0_full);

  assert_no_push_full1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo1_push |-> !fifo1_full);

  assert_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !busy);

  assert_hw_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_start && cur_hw) |-> hw_trig);

  assert_word_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo0_push || fifo1_push) |-> (push_word[31:20] == 12'd0 && push_word[15:12] == 4'd0));

  assert_eos_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eos_evt |-> !busy);
endmodule

bind adc_step_seq adc_step_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .adc_req(adc_req),
  .fifo0_push(fifo0_push), .fifo1_push(fifo1_push),
  .fifo0_full(fifo0_full), .fifo1_full(fifo1_full),
  .ovr0_evt(ovr0_evt), .ovr1_evt(ovr1_evt), .run_en(run_en),
  .eos_evt(eos_evt), .step_start(step_start), .cur_hw(cur_hw),
  .hw_trig(hw_trig), .push_word(push_word)
);

// File: tb/adc_step_seq_test.sv
module adc_step_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hw_trig = 1'b0;
  logic        adc_req, adc_ack = 1'b0;
  logic [3:0]  adc_chan;
  logic [11:0] adc_data = '0;
  logic        fifo0_push, fifo1_push, fifo0_full = 1'b0, fifo1_full = 1'b0;
  logic [31:0] push_word;
  logic [6:0]  fifo0_level = '0, fifo1_level = '0;
  logic        busy, irq;
  logic [4:0]  status;

  always #2 clk = ~clk;

  adc_step_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hw_trig(hw_trig), .adc_req(adc_req), .adc_chan(adc_chan), .adc_ack(adc_ack),
    .adc_data(adc_data), .fifo0_push(fifo0_push), .fifo1_push(fifo1_push),
    .push_word(push_word), .fifo0_full(fifo0_full), .fifo1_full(fifo1_full),
    .fifo0_level(fifo0_level), .fifo1_level(fifo1_level), .busy(busy),
    .status(status), .irq(irq)
  );

  int checks = 0, errors = 0, pushes = 0;
  int run_len = 0, conv_k = 0, samp_j = 0;
  int runs[$];
  int exp_word[$], exp_f1[$], exp_dur[$];
  int b_mode[17], b_avg[17], b_chan[17], b_f1[17], b_open[17], b_samp[17];
  bit b_tag = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sval(input int chan, input int j);
    return (chan * 300 + j * 111 + 7) % 4096;
  endfunction

  // behavioural converter: acknowledges in the 13th cycle of a request
  always @(negedge clk) begin
    if (!busy) samp_j = 0;
    if (adc_req) begin
      if (conv_k == 12) begin
        adc_ack  = 1'b1;
        adc_data = 12'(sval(int'(adc_chan), samp_j));
        samp_j++;
        conv_k = 0;
      end else begin
        adc_ack = 1'b0;
        conv_k++;
      end
    end else begin
      adc_ack = 1'b0;
      conv_k  = 0;
    end
  end

  // reference comparison every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) run_len++;
      if (fifo0_push || fifo1_push) begin
        pushes++;
        if (exp_word.size() == 0) begin
          chk(1'b0, "R7 unexpected push", int'(push_word), -1);
        end else begin
          int w, f, d;
          w = exp_word.pop_front();
          f = exp_f1.pop_front();
          d = exp_dur.pop_front();
          // R3: queue order enforces ascending slot order
          chk(int'(push_word) == w, "R5 R6 word", int'(push_word), w);
          chk(int'(fifo1_push) == f, "R7 fifo", int'(fifo1_push), f);
          chk(run_len == d, "R4 duration", run_len, d);
        end
      end
      if (!busy && run_len > 0) begin
        runs.push_back(run_len);
        run_len = 0;
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg_slot(input int s, input int mode, input int avg, input int chan,
                          input int f1, input int opn, input int smp);
    b_mode[s] = mode; b_avg[s] = avg; b_chan[s] = chan; b_f1[s] = f1;
    b_open[s] = opn; b_samp[s] = smp;
    wr(32 + 2 * s, mode | (avg << 2) | (chan << 19) | (f1 << 26));
    wr(33 + 2 * s, opn | (smp << 24));
  endtask

  task automatic expect_step(input int s);
    int e, n, sum, w;
    e = (b_avg[s] > 4) ? 4 : b_avg[s];
    n = 1 << e;
    sum = 0;
    for (int j = 0; j < n; j++) sum += sval(b_chan[s], j);
    w = (sum >> e) & 12'hFFF;
    if (b_tag) w = w | ((s - 1) << 16);
    exp_word.push_back(w);
    exp_f1.push_back(b_f1[s]);
    exp_dur.push_back(b_open[s] + 2 + n * (b_samp[s] + 14));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(busy == 1'b0 && adc_req == 1'b0, "R1 busy/req", int'(busy), 0);
    chk(status == 5'd0 && irq == 1'b0, "R1 status/irq", int'(status), 0);
    chk(fifo0_push == 1'b0 && fifo1_push == 1'b0, "R1 push", int'(fifo0_push), 0);

    // single tagged one-shot step (R13 address map used throughout)
    cfg_slot(1, 0, 0, 5, 0, 3, 2);
    b_tag = 1'b1;
    expect_step(1);
    wr(5, 1);
    wr(1, 32'h2);
    wr(0, 3);
    idle(60);
    chk(exp_word.size() == 0 && pushes == 1, "R4 single step done", pushes, 1);
    chk(status[0] == 1'b1, "R9 eos set", int'(status), 1);
    chk(irq == 1'b1, "R12 eos irq", int'(irq), 1);
    idle(100);
    chk(pushes == 1, "R10 one-shot retired", pushes, 1);
    wr(4, 1);
    idle(1);
    chk(status[0] == 1'b0 && irq == 1'b0, "R9 eos clear", int'(status), 0);

    // several steps, untagged, mixed averaging and destinations
    b_tag = 1'b0;
    wr(0, 1);
    cfg_slot(9, 0, 4, 2, 0, 0, 0);
    cfg_slot(3, 0, 2, 11, 1, 5, 1);
    cfg_slot(12, 0, 6, 7, 1, 1, 3);
    expect_step(3);
    expect_step(9);
    expect_step(12);
    wr(1, (1 << 3) | (1 << 9) | (1 << 12));
    idle(900);
    chk(pushes == 4 && exp_word.size() == 0, "R3 ordered multi-step", pushes, 4);

    // overrun on FIFO1
    fifo1_full = 1'b1;
    cfg_slot(2, 0, 0, 1, 1, 0, 0);
    wr(1, 1 << 2);
    idle(60);
    chk(pushes == 4, "R8 no push when full", pushes, 4);
    chk(status[2] == 1'b1 && status[1] == 1'b0, "R8 overrun flag", int'(status), 5);
    fifo1_full = 1'b0;
    wr(4, 7);

    // hardware-synchronised step
    cfg_slot(5, 2, 1, 3, 0, 2, 0);
    base = runs.size();
    wr(1, 1 << 5);
    idle(50);
    chk(pushes == 4 && runs.size() == base, "R10 waits for trigger", pushes, 4);
    expect_step(5);
    @(negedge clk); hw_trig = 1'b1;
    @(negedge clk); hw_trig = 1'b0;
    idle(60);
    chk(pushes == 5, "R10 triggered step", pushes, 5);
    idle(50);
    chk(pushes == 5, "R10 hw step waits again", pushes, 5);
    wr(1, 0);

    // run cleared: nothing starts; then charge step followed by step 1
    wr(0, 0);
    cfg_slot(0, 0, 0, 0, 0, 10, 0);
    cfg_slot(1, 0, 0, 5, 0, 3, 2);
    wr(1, 32'h3);
    base = runs.size();
    idle(40);
    chk(runs.size() == base && pushes == 5, "R2 run off no step", runs.size() - base, 0);
    runs.delete();
    expect_step(1);
    wr(0, 1);
    idle(80);
    chk(runs.size() == 2, "R11 two busy runs", runs.size(), 2);
    if (runs.size() > 0) chk(runs[0] == 11, "R11 charge length", runs[0], 11);
    chk(pushes == 6, "R11 charge no push", pushes, 6);

    // software continuous step
    cfg_slot(4, 1, 0, 9, 0, 0, 0);
    for (int i = 0; i < 3; i++) expect_step(4);
    wr(1, 1 << 4);
    for (int i = 0; i < 400 && pushes < 9; i++) @(negedge clk);
    wr(0, 0);
    idle(50);
    chk(pushes == 9, "R10 continuous repeats", pushes, 9);
    chk(busy == 1'b0, "R2 stopped", int'(busy), 0);
    chk(status[0] == 1'b1, "R9 eos each pass", int'(status), 1);

    // abort mid-step
    cfg_slot(4, 1, 0, 9, 0, 200, 0);
    wr(0, 1);
    idle(20);
    chk(busy == 1'b1, "R4 long open busy", int'(busy), 1);
    wr(0, 0);
    idle(1);
    chk(busy == 1'b0, "R2 abort", int'(busy), 0);

    // threshold interrupt
    wr(4, 7);
    wr(2, 4);
    wr(5, 32'h08);
    fifo0_level = 7'd5;
    idle(1);
    chk(status[3] == 1'b1 && irq == 1'b1, "R12 threshold hit", int'(status), 8);
    fifo0_level = 7'd3;
    idle(1);
    chk(status[3] == 1'b0 && irq == 1'b0, "R12 threshold clear", int'(status), 0);
    chk(exp_word.size() == 0 && pushes == 9, "R7 no stray push", pushes, 9);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule